// File: doc/BRIEF.md
# Byte-Wide Arithmetic/Logic Unit with Status Flags

This block performs one arithmetic, logic or rotate operation per cycle on an 8-bit accumulator value and a second 8-bit operand. The result is combinational. Five condition flags are held in a small register: sign, zero, half carry (carry out of bit 3), even parity and carry. They are updated on the clock edge at which the caller marks the operation valid. The stored carry feeds the carry-in and borrow-in operations and the rotates. The flags are always visible as one status byte with fixed bit positions.

The surrounding datapath presents the operands and an operation code, takes `result_o` when `wr_result_o` is high, and reads the flags from `status_o`. A compare sets the flags as a subtract would, but its difference is not returned, so the accumulator value is left as it was.

Top module: `alu8_core`

## Requirements
- R1: `status_o` packs the flags as S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0. Bit 1 is always 1 and bits 3 and 5 are always 0. After a synchronous reset the byte is 8'h02.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, INC=4, DEC=5, AND=6, OR=7, XOR=8, CMA=9, CMP=10, CLR=11, RLC=12 and RRC=13. Codes 14 and 15 are reserved. ADD returns (acc+opnd) mod 256, with CY set to the carry out of bit 7 and AC set to the carry out of bit 3.
- R3: SUB computes acc + ~opnd + 1 mod 256. CY is the borrow, meaning the inverse of the carry out of bit 7. AC is the carry out of bit 3 of that same sum.
- R4: CMP sets all five flags exactly as SUB would. Its `result_o` equals `acc_i` and `wr_result_o` is 0.
- R5: For ADD, ADC, SUB, SBB, CMP, INC, DEC, AND, OR, XOR and CLR, S equals bit 7 of the computed value. Z is 1 when that value is 0. P is 1 when the value has an even number of 1 bits.
- R6: INC returns acc+1 with AC = (acc[3:0]==4'hF). DEC returns acc-1 with AC = (acc[3:0]!=0). Both update S, Z and P and leave CY unchanged.
- R7: AND, OR and XOR return the bitwise result and clear CY. AND sets AC to 1, while OR and XOR clear AC.
- R8: CLR returns 0 and sets the flags to S=0, Z=1, AC=0, P=1, CY=0. CMA returns ~acc and leaves all flags unchanged.
- R9: RLC returns {acc[6:0],acc[7]} with CY=acc[7]. RRC returns {acc[0],acc[7:1]} with CY=acc[0]. Both leave S, Z, AC and P unchanged.
- R10: The flags change only on a clock edge with `op_valid_i` high. Reserved codes return acc, drive `wr_result_o` low and leave the flags unchanged.
- R11: ADC adds the stored CY as carry-in. SBB computes acc + ~opnd + (1 - CY), so the stored CY acts as borrow-in. The flags follow R2 for ADC and R3 for SBB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Commit this cycle's flag update |
| op_i | input | 4 | Operation code (R2) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| wr_result_o | output | 1 | Result should be written back |
| status_o | output | 8 | Registered status byte |

## Verification
The bench targets the nibble boundaries (0x0F+0x01, 0x10-0x01, INC of xF, DEC of x0) where a half-carry computed on the wrong operand or with the wrong polarity flips AC. It also targets 0x00-0x01 and equal operands, where an inverted borrow gives the wrong CY. Chains of ADC and SBB after carry-setting operations would expose a carry-in read from the wrong source. INC, DEC, CMA, rotates, reserved codes and idle cycles placed after a set carry would expose a design that writes flags it should keep.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
        OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_AND = 4'd6,  OP_OR  = 4'd7,
        OP_XOR = 4'd8,  OP_CMA = 4'd9,  OP_CMP = 4'd10, OP_CLR = 4'd11,
        OP_RLC = 4'd12, OP_RRC = 4'd13, OP_RSV14 = 4'd14, OP_RSV15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    localparam flags_t FLAGS_RST = '{s: 1'b0, z: 1'b0, ac: 1'b0, p: 1'b0, cy: 1'b0};

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

    function automatic logic is_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    endfunction

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || is_subtract(op) ||
               (op == OP_INC) || (op == OP_DEC);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int HW = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         hcarry_o
);
    logic [HW:0]   low_sum;
    logic [W-HW:0] high_sum;

    always_comb begin
        low_sum  = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, cin_i};
        high_sum = {1'b0, a_i[W-1:HW]} + {1'b0, b_i[W-1:HW]} + {{(W-HW){1'b0}}, low_sum[HW]};
        sum_o    = {high_sum[W-HW-1:0], low_sum[HW-1:0]};
        cout_o   = high_sum[W-HW];
        hcarry_o = low_sum[HW];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         shout_o
);
    always_comb begin
        res_o   = a_i;
        shout_o = 1'b0;
        unique case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CMA: res_o = ~a_i;
            OP_CLR: res_o = '0;
            OP_RLC: begin
                res_o   = {a_i[W-2:0], a_i[W-1]};
                shout_o = a_i[W-1];
            end
            OP_RRC: begin
                res_o   = {a_i[0], a_i[W-1:1]};
                shout_o = a_i[0];
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_i,
    input  flags_t d_i,
    output flags_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= FLAGS_RST;
        end else if (en_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_result_o,
    output logic [DATA_W-1:0] status_o
);
    alu_op_e           op;
    flags_t            flags_q;
    flags_t            flags_d;
    logic              flag_en;
    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              hcarry;
    logic [DATA_W-1:0] lres;
    logic              shout;

    assign op = alu_op_e'(op_i);

    // Operand and carry-in selection for the shared adder
    always_comb begin
        b_eff = '0;
        cin   = 1'b0;
        unique case (op)
            OP_ADD:         begin b_eff = opnd_i;  cin = 1'b0;        end
            OP_ADC:         begin b_eff = opnd_i;  cin = flags_q.cy;  end
            OP_SUB, OP_CMP: begin b_eff = ~opnd_i; cin = 1'b1;        end
            OP_SBB:         begin b_eff = ~opnd_i; cin = ~flags_q.cy; end
            OP_INC:         begin b_eff = '0;      cin = 1'b1;        end
            OP_DEC:         begin b_eff = '1;      cin = 1'b0;        end
            default:        begin b_eff = '0;      cin = 1'b0;        end
        endcase
    end

    alu8_addsub #(.W(DATA_W), .HW(NIB_W)) u_addsub (
        .a_i      (acc_i),
        .b_i      (b_eff),
        .cin_i    (cin),
        .sum_o    (sum),
        .cout_o   (cout),
        .hcarry_o (hcarry)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .op_i    (op),
        .a_i     (acc_i),
        .b_i     (opnd_i),
        .res_o   (lres),
        .shout_o (shout)
    );

    // Result path and next flag values
    always_comb begin
        flags_d     = flags_q;
        result_o    = acc_i;
        wr_result_o = 1'b1;
        flag_en     = op_valid_i;
        if (is_arith(op)) begin
            result_o   = (op == OP_CMP) ? acc_i : sum;
            flags_d.s  = sum[DATA_W-1];
            flags_d.z  = (sum == '0);
            flags_d.p  = even_parity(sum);
            flags_d.ac = hcarry;
            if (is_subtract(op)) begin
                flags_d.cy = ~cout;
            end else if ((op == OP_ADD) || (op == OP_ADC)) begin
                flags_d.cy = cout;
            end
            if (op == OP_CMP) begin
                wr_result_o = 1'b0;
            end
        end else begin
            result_o = lres;
            unique case (op)
                OP_AND, OP_OR, OP_XOR, OP_CLR: begin
                    flags_d.s  = lres[DATA_W-1];
                    flags_d.z  = (lres == '0);
                    flags_d.p  = even_parity(lres);
                    flags_d.ac = (op == OP_AND);
                    flags_d.cy = 1'b0;
                end
                OP_RLC, OP_RRC: flags_d.cy = shout;
                OP_CMA:         flag_en    = 1'b0;
                default: begin
                    flag_en     = 1'b0;
                    wr_result_o = 1'b0;
                end
            endcase
        end
    end

    alu8_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .en_i (flag_en),
        .d_i  (flags_d),
        .q_o  (flags_q)
    );

    assign status_o = pack_status(flags_q);
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid_i,
    input logic [3:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] result_o,
    input logic       wr_result_o,
    input logic [7:0] status_o
);
    logic flag_z_op;
    assign flag_z_op = (op_i <= 4'd8) || (op_i == 4'd10) || (op_i == 4'd11);

    assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (rst)
        status_o[1] && !status_o[3] && !status_o[5]);

    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd10) |-> (!wr_result_o && result_o == acc_i));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && flag_z_op && op_i != 4'd10) |=> (status_o[6] == ($past(result_o) == 8'h00)));

    assert_incdec_keep_cy_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && (op_i == 4'd4 || op_i == 4'd5)) |=> (status_o[0] == $past(status_o[0])));

    assert_logic_cy_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && (op_i == 4'd6 || op_i == 4'd7 || op_i == 4'd8)) |=>
            (!status_o[0] && (status_o[4] == ($past(op_i) == 4'd6))));

    assert_rot_carry_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && op_i == 4'd12) |=> (status_o[0] == $past(acc_i[7])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> $stable(status_o));
endmodule

bind alu8_core alu8_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .acc_i       (acc_i),
    .result_o    (result_o),
    .wr_result_o (wr_result_o),
    .status_o    (status_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid_i;
    logic [3:0] op_i;
    logic [7:0] acc_i;
    logic [7:0] opnd_i;
    logic [7:0] result_o;
    logic       wr_result_o;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fail   = 0;
    // reference flags
    int m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #4 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
        .wr_result_o(wr_result_o), .status_o(status_o)
    );

    function automatic string tag(input int op);
        case (op)
            0: return "R2"; 1, 3: return "R11"; 2: return "R3"; 4, 5: return "R6";
            6, 7, 8: return "R7"; 9, 11: return "R8"; 10: return "R4";
            12, 13: return "R9"; default: return "R10";
        endcase
    endfunction

    function automatic int par_even(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return ((c % 2) == 0) ? 1 : 0;
    endfunction

    function automatic int model_status();
        return m_s * 128 + m_z * 64 + m_ac * 16 + m_p * 4 + 2 + m_cy;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic szp(input int v);
        m_s = (v >> 7) & 1;
        m_z = (v == 0) ? 1 : 0;
        m_p = par_even(v);
    endtask

    task automatic do_op(input int op, input int a, input int b, input int valid);
        int res, wr, s, bin;
        @(negedge clk);
        op_valid_i = valid[0];
        op_i = op[3:0];
        acc_i = a[7:0];
        opnd_i = b[7:0];
        res = a; wr = 1;
        case (op)
            0, 1: begin
                s = a + b + ((op == 1) ? m_cy : 0);
                res = s & 255;
                if (valid) begin
                    m_ac = ((a & 15) + (b & 15) + ((op == 1) ? m_cy : 0)) > 15;
                    m_cy = (s > 255) ? 1 : 0; szp(res);
                end
            end
            2, 3, 10: begin
                bin = (op == 3) ? m_cy : 0;
                s = a + (255 - b) + (1 - bin);
                res = (op == 10) ? a : (s & 255);
                if (op == 10) wr = 0;
                if (valid) begin
                    m_ac = ((a & 15) + (15 - (b & 15)) + (1 - bin)) > 15;
                    m_cy = (s > 255) ? 0 : 1; szp(s & 255);
                end
            end
            4: begin res = (a + 1) & 255; if (valid) begin m_ac = ((a & 15) == 15); szp(res); end end
            5: begin res = (a + 255) & 255; if (valid) begin m_ac = ((a & 15) != 0); szp(res); end end
            6, 7, 8, 11: begin
                res = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (op == 8) ? (a ^ b) : 0;
                if (valid) begin m_ac = (op == 6); m_cy = 0; szp(res); end
            end
            9: res = 255 - a;
            12: begin res = ((a << 1) | (a >> 7)) & 255; if (valid) m_cy = (a >> 7) & 1; end
            13: begin res = ((a >> 1) | (a << 7)) & 255; if (valid) m_cy = a & 1; end
            default: begin res = a; wr = 0; end
        endcase
        #1;
        check(tag(op), int'(result_o), res, $sformatf("result op%0d a=%0h b=%0h", op, a, b));
        check(tag(op), int'(wr_result_o), wr, "wr_result");
        @(posedge clk); #1;
        check(valid ? tag(op) : "R10", int'(status_o), model_status(),
              $sformatf("status after op%0d a=%0h b=%0h v=%0d", op, a, b, valid));
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid_i = 1'b0; op_i = '0; acc_i = '0; opnd_i = '0;
        repeat (3) @(posedge clk);
        #1 check("R1", int'(status_o), 8'h02, "reset status");
        @(negedge clk) rst = 1'b0;
        // R2 nibble and byte carries
        do_op(0, 8'h0F, 8'h01, 1);
        do_op(0, 8'hFF, 8'h01, 1);
        do_op(0, 8'h7F, 8'h01, 1);
        // R11 carry-in chains
        do_op(1, 8'h10, 8'h20, 1);
        do_op(0, 8'h80, 8'h80, 1);
        do_op(1, 8'h10, 8'h20, 1);
        // R3 borrow cases
        do_op(2, 8'h00, 8'h01, 1);
        do_op(3, 8'h10, 8'h01, 1);
        do_op(2, 8'h42, 8'h42, 1);
        do_op(3, 8'h42, 8'h42, 1);
        // R4 compare
        do_op(10, 8'h05, 8'h09, 1);
        do_op(10, 8'h33, 8'h33, 1);
        // R6 inc/dec keep carry (carry is set first)
        do_op(2, 8'h00, 8'h01, 1);
        do_op(4, 8'h0F, 8'h00, 1);
        do_op(4, 8'hFF, 8'h00, 1);
        do_op(5, 8'h10, 8'h00, 1);
        do_op(5, 8'h01, 8'h00, 1);
        // R7 logic
        do_op(6, 8'hF0, 8'h3C, 1);
        do_op(0, 8'hFF, 8'hFF, 1);
        do_op(7, 8'h00, 8'h00, 1);
        do_op(8, 8'hA5, 8'h5A, 1);
        // R8 clear / complement
        do_op(0, 8'hFF, 8'h01, 1);
        do_op(9, 8'h3C, 8'h00, 1);
        do_op(11, 8'h77, 8'h12, 1);
        // R9 rotates
        do_op(12, 8'h81, 8'h00, 1);
        do_op(13, 8'h02, 8'h00, 1);
        do_op(13, 8'h03, 8'h00, 1);
        // R10 idle and reserved codes
        do_op(0, 8'hFF, 8'h01, 1);
        do_op(0, 8'h00, 8'h00, 0);
        do_op(14, 8'h5A, 8'h00, 1);
        do_op(15, 8'h01, 8'hFF, 1);
        do_op(6, 8'h00, 8'h00, 0);
        // mixed stream
        for (int k = 0; k < 200; k++) begin
            do_op(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 3) != 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule